// File: doc/BRIEF.md
# Clock Divider Parameter Search

This block is a sequential search engine for a programmable clock divider. Given a requested output rate and the frequencies of three candidate sources (an external oscillator and two PLLs), it tries every pairing of source and predivider. For each pairing it works out an integer post-divider and the rate that divider would actually give. It then reports the register settings whose achieved rate lies closest to the request. The predivider can be 2, 2.5 or 3. To stay in integer arithmetic the engine works with twice each source frequency and twice each predivider, so the three predividers become 4, 5 and 6.

A search begins with a single-cycle `start` pulse while the engine is idle. The engine captures the request and the source frequencies at that moment. It then evaluates nine candidates one after another, using one shared multi-cycle restoring divider, and signals completion with a one-cycle `done` pulse. The result fields hold their values until the next accepted start. Writing the settings into a clock control register, and producing the clock itself, are the job of surrounding logic.

Top module: `clkdiv_search`

## Requirements
- R1: At an accepted start, the request is limited to floor(max(f_ext, f_pll1, f_pll2) / 4). A larger request is replaced by that limit before the search.
- R2: Candidates are visited with the source as the outer loop (external, then PLL1, then PLL2) and the doubled predivider as the inner loop (4, 5, 6). The result encodes the predivider as `pre_code` = doubled predivider − 3, so 1 means 2, 2 means 2.5 and 3 means 3. `sel_pll` is 1 for either PLL and `sel_pll2` is 1 only for PLL2.
- R3: The candidate divider is floor(2·f / (request · doubled predivider)). A candidate whose divider falls outside 2..127 is discarded.
- R4: The achieved rate of a candidate is floor(2·f / (doubled predivider · divider)). A candidate becomes the result only if no result exists yet or if its absolute error to the limited request is strictly smaller than the error of the current result. On a tie the earlier candidate is kept.
- R5: If no candidate survives, `found` is 0 and `rate_out`, `div_val`, `pre_code`, `sel_pll` and `sel_pll2` are all 0. This includes a zero request and a zero limit.
- R6: `done` is high for exactly one cycle after all nine candidates have been evaluated. In the cycle after `done`, `busy` is low.
- R7: `busy` rises in the cycle after an accepted start. A `start` pulse while busy is ignored, and so are changes of the request and frequency inputs during a search.
- R8: While idle and without a start, the result outputs do not change, whatever the data inputs do.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (honoured only while idle) |
| req_rate | input | FREQ_W | Requested output rate |
| f_ext | input | FREQ_W | External source frequency |
| f_pll1 | input | FREQ_W | First PLL frequency |
| f_pll2 | input | FREQ_W | Second PLL frequency |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A valid setting was found |
| sel_pll | output | 1 | Result uses a PLL source |
| sel_pll2 | output | 1 | Result uses the second PLL |
| pre_code | output | 2 | Predivider code (1, 2, 3) |
| div_val | output | 7 | Post-divider value |
| rate_out | output | FREQ_W | Achieved rate, 0 when nothing found |

## Verification
The bench aims at the tie rule by giving all three sources the same frequency. A design that replaced the result on equal error would report a PLL instead of the external source. Oversized requests test the limit step; a design without it would pick dividers that are far too small. Requests that are too small for any divider, zero requests, and near-zero sources must all come back as "not found" with zeroed fields. A design that did not reset its result at start, or that divided by zero wrongly, would leak stale settings here. A second start and new input values in the middle of a search must leave the result of the first search intact, and the result must stay unchanged once the engine is idle. A design that re-armed during a search would show a second `done` pulse or a changed result.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;
    localparam int unsigned N_SRC    = 3;
    localparam int unsigned PD_W     = 3;
    localparam int unsigned PD_FIRST = 4;
    localparam int unsigned PD_LAST  = 6;
    localparam int unsigned CODE_OFS = 3;
    localparam int unsigned DIV_W    = 7;
    localparam int unsigned DIV_MIN  = 2;
    localparam int unsigned DIV_MAX  = 127;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_Q,
        ST_WAIT_Q,
        ST_LOAD_R,
        ST_WAIT_R,
        ST_STEP,
        ST_DONE
    } search_st_e;
endpackage

// File: rtl/clkdiv_rdiv.sv
// Restoring unsigned divider, one quotient bit per cycle.
// valid pulses one cycle after the last step; quot holds until next start.
module clkdiv_rdiv #(
    parameter int unsigned W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic         valid
);
    localparam int unsigned CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          valid;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dsr;
    } dv_t;

    dv_t q, d;
    logic [W:0] rem_sh;
    logic [W:0] diff;
    logic       ge;

    always_comb begin
        d      = q;
        d.valid = 1'b0;
        rem_sh = {q.rem, q.quo[W-1]};
        diff   = rem_sh - {1'b0, q.dsr};
        ge     = (rem_sh >= {1'b0, q.dsr});
        if (start) begin
            d.run = 1'b1;
            d.cnt = CW'(W);
            d.rem = '0;
            d.quo = dividend;
            d.dsr = divisor;
        end else if (q.run) begin
            // a divisor of zero always subtracts: quotient becomes all ones
            d.rem = W'(ge ? diff : rem_sh);
            d.quo = {q.quo[W-2:0], ge};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run   = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quot  = q.quo;
    assign valid = q.valid;
endmodule

// File: rtl/clkdiv_limit.sv
// Limits the request to the fastest source divided by four.
module clkdiv_limit #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] f_a,
    input  logic [W-1:0] f_b,
    input  logic [W-1:0] f_c,
    input  logic [W-1:0] req,
    output logic [W-1:0] req_lim
);
    logic [W-1:0] m_ab;
    logic [W-1:0] m_abc;
    logic [W-1:0] ceil_v;

    always_comb begin
        m_ab    = (f_a > f_b) ? f_a : f_b;
        m_abc   = (m_ab > f_c) ? m_ab : f_c;
        ceil_v  = m_abc >> 2;
        req_lim = (req > ceil_v) ? ceil_v : req;
    end
endmodule

// File: rtl/clkdiv_score.sv
// Absolute error of a candidate and the strict-improvement decision.
module clkdiv_score #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] target,
    input  logic [W-1:0] best_err,
    input  logic         have_best,
    output logic [W-1:0] err,
    output logic         better
);
    always_comb begin
        err    = (cand >= target) ? (cand - target) : (target - cand);
        better = !have_best || (err < best_err);
    end
endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
    import clkdiv_search_pkg::*;
#(
    parameter int unsigned FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_rate,
    input  logic [FREQ_W-1:0] f_ext,
    input  logic [FREQ_W-1:0] f_pll1,
    input  logic [FREQ_W-1:0] f_pll2,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              sel_pll,
    output logic              sel_pll2,
    output logic [1:0]        pre_code,
    output logic [DIV_W-1:0]  div_val,
    output logic [FREQ_W-1:0] rate_out
);
    localparam int unsigned MW = FREQ_W + 1;   // doubled source frequency
    localparam int unsigned DW = FREQ_W + 3;   // divider width (request x 6)

    typedef struct packed {
        search_st_e                     st;
        logic [1:0]                     src;
        logic [PD_W-1:0]                pd;
        logic [FREQ_W-1:0]              req;
        logic [N_SRC-1:0][FREQ_W-1:0]   fsrc;
        logic [DIV_W-1:0]               cdiv;
        logic                           found;
        logic                           esel;
        logic                           psel;
        logic [1:0]                     code;
        logic [DIV_W-1:0]               div;
        logic [FREQ_W-1:0]              rate;
        logic [FREQ_W-1:0]              err;
    } ctx_t;

    ctx_t q, n;

    logic [FREQ_W-1:0] req_lim;
    logic [FREQ_W-1:0] f_cur;
    logic [MW-1:0]     mclk;
    logic [DW-1:0]     req_x_pd;
    logic [DW-1:0]     pd_x_div;
    logic              dv_start;
    logic [DW-1:0]     dv_dsr;
    logic [DW-1:0]     dv_quot;
    logic              dv_valid;
    logic              q_in_range;
    logic [FREQ_W-1:0] rate_cand;
    logic [FREQ_W-1:0] cand_err;
    logic              cand_better;

    clkdiv_limit #(.W(FREQ_W)) i_limit (
        .f_a     (f_ext),
        .f_b     (f_pll1),
        .f_c     (f_pll2),
        .req     (req_rate),
        .req_lim (req_lim)
    );

    clkdiv_rdiv #(.W(DW)) i_rdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dv_start),
        .dividend (DW'(mclk)),
        .divisor  (dv_dsr),
        .quot     (dv_quot),
        .valid    (dv_valid)
    );

    clkdiv_score #(.W(FREQ_W)) i_score (
        .cand      (rate_cand),
        .target    (q.req),
        .best_err  (q.err),
        .have_best (q.found),
        .err       (cand_err),
        .better    (cand_better)
    );

    // operand preparation
    always_comb begin
        case (q.src)
            2'd0:    f_cur = q.fsrc[0];
            2'd1:    f_cur = q.fsrc[1];
            default: f_cur = q.fsrc[2];
        endcase
        mclk       = {f_cur, 1'b0};
        req_x_pd   = DW'(q.req) * DW'(q.pd);
        pd_x_div   = DW'(q.pd) * DW'(q.cdiv);
        q_in_range = (dv_quot >= DW'(DIV_MIN)) && (dv_quot <= DW'(DIV_MAX));
        rate_cand  = FREQ_W'(dv_quot);
    end

    // next-state logic
    always_comb begin
        n        = q;
        dv_start = 1'b0;
        dv_dsr   = req_x_pd;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.st      = ST_LOAD_Q;
                    n.fsrc[0] = f_ext;
                    n.fsrc[1] = f_pll1;
                    n.fsrc[2] = f_pll2;
                    n.req     = req_lim;
                    n.src     = 2'd0;
                    n.pd      = PD_W'(PD_FIRST);
                    n.cdiv    = '0;
                    n.found   = 1'b0;
                    n.esel    = 1'b0;
                    n.psel    = 1'b0;
                    n.code    = '0;
                    n.div     = '0;
                    n.rate    = '0;
                    n.err     = '1;
                end
            end
            ST_LOAD_Q: begin
                dv_start = 1'b1;
                dv_dsr   = req_x_pd;
                n.st     = ST_WAIT_Q;
            end
            ST_WAIT_Q: begin
                if (dv_valid) begin
                    if (q_in_range) begin
                        n.cdiv = DIV_W'(dv_quot);
                        n.st   = ST_LOAD_R;
                    end else begin
                        n.st   = ST_STEP;
                    end
                end
            end
            ST_LOAD_R: begin
                dv_start = 1'b1;
                dv_dsr   = pd_x_div;
                n.st     = ST_WAIT_R;
            end
            ST_WAIT_R: begin
                if (dv_valid) begin
                    if (cand_better) begin
                        n.found = 1'b1;
                        n.esel  = (q.src != 2'd0);
                        n.psel  = (q.src == 2'd2);
                        n.code  = 2'(q.pd - PD_W'(CODE_OFS));
                        n.div   = q.cdiv;
                        n.rate  = rate_cand;
                        n.err   = cand_err;
                    end
                    n.st = ST_STEP;
                end
            end
            ST_STEP: begin
                if (q.pd == PD_W'(PD_LAST)) begin
                    if (q.src == 2'(N_SRC - 1)) begin
                        n.st = ST_DONE;
                    end else begin
                        n.src = q.src + 2'd1;
                        n.pd  = PD_W'(PD_FIRST);
                        n.st  = ST_LOAD_Q;
                    end
                end else begin
                    n.pd = q.pd + PD_W'(1);
                    n.st = ST_LOAD_Q;
                end
            end
            ST_DONE: n.st = ST_IDLE;
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = (q.st == ST_DONE);
    assign found    = q.found;
    assign sel_pll  = q.esel;
    assign sel_pll2 = q.psel;
    assign pre_code = q.code;
    assign div_val  = q.div;
    assign rate_out = q.rate;
endmodule

// File: rtl/clkdiv_search_chk.sv
module clkdiv_search_chk #(
    parameter int unsigned FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              sel_pll,
    input logic              sel_pll2,
    input logic [1:0]        pre_code,
    input logic [6:0]        div_val,
    input logic [FREQ_W-1:0] rate_out
);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    a_r5_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (rate_out == '0 && div_val == '0 && pre_code == 2'd0
                              && !sel_pll && !sel_pll2));

    a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (div_val >= 7'd2 && div_val <= 7'd127));

    a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (pre_code >= 2'd1 && pre_code <= 2'd3));

    a_r2_pll2_is_pll: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pll2 |-> sel_pll);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(rate_out) && $stable(div_val) && $stable(found)
                               && $stable(pre_code) && $stable(sel_pll) && $stable(sel_pll2)));
endmodule

bind clkdiv_search clkdiv_search_chk #(.FREQ_W(FREQ_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .found    (found),
    .sel_pll  (sel_pll),
    .sel_pll2 (sel_pll2),
    .pre_code (pre_code),
    .div_val  (div_val),
    .rate_out (rate_out)
);

// File: tb/test_clkdiv_search.sv
`timescale 1ns/1ps
module test_clkdiv_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_rate = '0;
    logic [31:0] f_ext = '0;
    logic [31:0] f_pll1 = '0;
    logic [31:0] f_pll2 = '0;
    logic        busy, done, found, sel_pll, sel_pll2;
    logic [1:0]  pre_code;
    logic [6:0]  div_val;
    logic [31:0] rate_out;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    clkdiv_search #(.FREQ_W(32)) i_clkdiv_search (
        .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
        .f_ext(f_ext), .f_pll1(f_pll1), .f_pll2(f_pll2),
        .busy(busy), .done(done), .found(found), .sel_pll(sel_pll),
        .sel_pll2(sel_pll2), .pre_code(pre_code), .div_val(div_val),
        .rate_out(rate_out)
    );

    always @(negedge clk) if (done) done_cnt++;

    typedef struct packed {
        logic [31:0] req;
        logic [31:0] fe;
        logic [31:0] f1;
        logic [31:0] f2;
    } vec_t;

    typedef struct {
        logic      fnd;
        logic      es;
        logic      ps;
        int        code;
        int        dv;
        longint    rate;
    } res_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'd25000000,  32'd14745600, 32'd400000000, 32'd192000000},
        '{32'd6000000,   32'd14745600, 32'd400000000, 32'd192000000},
        '{32'hFFFFFFFF,  32'd14745600, 32'd400000000, 32'd192000000},
        '{32'd1000000,   32'd14745600, 32'd0,         32'd0},
        '{32'd10000,     32'd14745600, 32'd0,         32'd0},
        '{32'd7372800,   32'd14745600, 32'd300000000, 32'd250000000},
        '{32'd0,         32'd14745600, 32'd400000000, 32'd192000000},
        '{32'd3,         32'd3,        32'd3,         32'd3}
    };

    // Independent model of the requirements (R1..R5)
    function automatic res_t model(input vec_t v);
        res_t   r;
        longint f [3];
        longint mx, lim, m, dv, a, e, be;
        r.fnd = 1'b0; r.es = 1'b0; r.ps = 1'b0; r.code = 0; r.dv = 0; r.rate = 0;
        be = 0;
        f[0] = v.fe; f[1] = v.f1; f[2] = v.f2;
        mx = f[0];
        if (f[1] > mx) mx = f[1];
        if (f[2] > mx) mx = f[2];
        lim = (v.req > mx / 4) ? mx / 4 : longint'(v.req);
        for (int s = 0; s < 3; s++) begin
            m = 2 * f[s];
            for (int p = 4; p <= 6; p++) begin
                if (lim == 0) continue;
                dv = m / (lim * p);
                if (dv < 2 || dv > 127) continue;
                a = m / (p * dv);
                e = (a > lim) ? a - lim : lim - a;
                if (!r.fnd || e < be) begin
                    r.fnd = 1'b1; r.es = (s != 0); r.ps = (s == 2);
                    r.code = p - 3; r.dv = int'(dv); r.rate = a; be = e;
                end
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_res(input string tag, input res_t e);
        chk({tag, " found"},    found,    e.fnd);
        chk({tag, " sel_pll"},  sel_pll,  e.es);
        chk({tag, " sel_pll2"}, sel_pll2, e.ps);
        chk({tag, " pre_code"}, pre_code, e.code);
        chk({tag, " div_val"},  div_val,  e.dv);
        chk({tag, " rate"},     rate_out, e.rate);
    endtask

    task automatic apply(input vec_t v);
        req_rate = v.req; f_ext = v.fe; f_pll1 = v.f1; f_pll2 = v.f2;
    endtask

    // pulse start, then return at the negedge where done is high
    task automatic search(input vec_t v);
        int n;
        @(negedge clk);
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R6 done seen", done, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R6: watchdog expired, actual no finish expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        vec_t a, b;
        res_t ea, e;
        logic [31:0] held_rate;
        int base;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 busy",  busy, 0);
        chk("R9 done",  done, 0);
        chk("R9 found", found, 0);
        chk("R9 rate",  rate_out, 0);
        chk("R9 div",   div_val, 0);
        chk("R9 code",  pre_code, 0);
        rst_n = 1'b1;

        // Vector table: R1 limit, R2 order, R3 range, R4 best, R5 none
        for (int i = 0; i < NV; i++) begin
            search(VECS[i]);
            chk_res($sformatf("R4 vec%0d", i), model(VECS[i]));
        end

        // R4 tie: equal sources, external must win
        search('{32'd3000000, 32'd48000000, 32'd48000000, 32'd48000000});
        chk("R4 tie sel_pll", sel_pll, 0);
        chk("R4 tie div",     div_val, 8);
        chk("R4 tie code",    pre_code, 1);
        chk("R4 tie rate",    rate_out, 3000000);

        // R2: only PLL2 usable
        search('{32'd5000000, 32'd0, 32'd0, 32'd100000000});
        chk("R2 pll2 sel_pll",  sel_pll, 1);
        chk("R2 pll2 sel_pll2", sel_pll2, 1);
        chk("R2 pll2 div",      div_val, 10);
        chk("R2 pll2 rate",     rate_out, 5000000);

        // R1: request above limit, result equals limit with these sources
        search('{32'hFFFFFFFF, 32'd0, 32'd0, 32'd80000000});
        chk("R1 limit rate", rate_out, 20000000);

        // R5: zero request after a found result clears fields
        search('{32'd0, 32'd48000000, 32'd0, 32'd0});
        chk("R5 zero found", found, 0);
        chk("R5 zero rate",  rate_out, 0);

        // R6 / R7: done pulse and busy timing, restart ignored
        a = '{32'd6000000, 32'd14745600, 32'd400000000, 32'd192000000};
        b = '{32'd1000000, 32'd48000000, 32'd0, 32'd0};
        ea = model(a);
        @(negedge clk);
        apply(a);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", busy, 1);
        base = done_cnt;
        repeat (30) @(negedge clk);
        apply(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk_res("R7 restart ignored", ea);
        @(negedge clk);
        chk("R6 done one cycle", done, 0);
        chk("R6 idle after done", busy, 0);
        repeat (1200) @(negedge clk);
        chk("R7 single done", done_cnt - base, 1);

        // R8: outputs hold while idle as inputs move
        held_rate = rate_out;
        apply(b);
        repeat (20) @(negedge clk);
        e = ea;
        chk_res("R8 hold", e);
        chk("R8 hold rate", rate_out, held_rate);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule